// File: doc/BRIEF.md
# Memory Operation Issue Queue

This block holds memory operations (loads and stores, from both the integer and the vector/floating-point side) that have been dispatched but not yet issued. Each entry records its kind, a sequence number giving its program age, the tags of two address operands and, for stores, the tag of the store-data operand. Result tags broadcast by the execution units mark waiting operands as ready. Every cycle the queue offers at most one load and at most one store to the address-generation stage.

Selection follows memory-ordering rules. Loads leave in any order among themselves, and the oldest ready load goes first. No load leaves while a store of older program age still sits in the queue. Stores leave strictly in program order, and a store needs only its address operands; its data readiness travels with it. A flush with an age boundary removes every entry younger than that boundary in one cycle.

Top module: `mem_issue_queue`

## Requirements
- R1: The queue holds DEPTH (16) entries; disp_rdy is low exactly when all entries are occupied, and a dispatch presented while disp_rdy is low is dropped and never issues.
- R2: A load becomes eligible only when both address operands are ready; an issued load leaves the queue and is not offered again.
- R3: Ages are compared modulo 2^SEQW: a is older than b when (a - b) has its top bit set. Among eligible loads the oldest issues first, whatever slot it occupies and across sequence-number wrap.
- R4: A load does not issue while any store older than it is still in the queue, even if that store is not ready.
- R5: Stores issue in program order; a younger store whose address is ready waits behind an older waiting store.
- R6: A store with ready address operands issues whether or not its data operand is ready; st_drdy gives the data readiness at issue.
- R7: In one cycle at most one load and one store issue, and a load and a store may issue in the same cycle.
- R8: A wakeup broadcast on any port marks every matching waiting operand (address or data) ready for the following cycle; an operand whose tag is broadcast in the dispatch cycle is captured as ready.
- R9: When flush_vld is high, every entry whose sequence number is younger than flush_seq is removed at the next edge, a dispatch in the same cycle that is younger than flush_seq is dropped, and nothing issues in that cycle; older entries remain.
- R10: The vector flag given at dispatch comes back unchanged with the issued operation (ld_vec, st_vec).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_vld | input | 1 | Dispatch request |
| disp_rdy | output | 1 | A free entry exists |
| disp_st | input | 1 | 1 = store, 0 = load |
| disp_vec | input | 1 | 1 = vector/FP memory operation |
| disp_seq | input | SEQW | Program-age sequence number |
| disp_a0_tag | input | TAGW | First address operand tag |
| disp_a0_rdy | input | 1 | First address operand already ready |
| disp_a1_tag | input | TAGW | Second address operand tag |
| disp_a1_rdy | input | 1 | Second address operand already ready |
| disp_d_tag | input | TAGW | Store data operand tag |
| disp_d_rdy | input | 1 | Store data operand already ready |
| wk_vld | input | NWAKE | Wakeup broadcast valid per port |
| wk_tag | input | NWAKE*TAGW | Wakeup tags, port k in bits [k*TAGW +: TAGW] |
| flush_vld | input | 1 | Flush request |
| flush_seq | input | SEQW | Flush boundary; younger entries are removed |
| ld_vld | output | 1 | Load issued this cycle |
| ld_seq | output | SEQW | Sequence number of issued load |
| ld_vec | output | 1 | Vector flag of issued load |
| st_vld | output | 1 | Store issued this cycle |
| st_seq | output | SEQW | Sequence number of issued store |
| st_vec | output | 1 | Vector flag of issued store |
| st_dtag | output | TAGW | Data tag of issued store |
| st_drdy | output | 1 | Data of issued store is ready |

## Verification
Every cycle, the assertions check that an issued load matches a load held in the queue with no older store beside it, that issued store ages strictly increase, that occupancy grows by at most one per cycle, and that no entry younger than a flush boundary survives the flush. Oldest-first choice among loads, wrap-around of sequence numbers, same-cycle wakeup capture, data-readiness reporting, dropped dispatches into a full queue and suppression of issue during a flush are shown only by the bench scenarios, which compare the issued sequence numbers against the order the rules predict.

// File: rtl/mem_issue_queue.sv
module mem_issue_queue #(
  parameter int DEPTH = 16,
  parameter int TAGW  = 6,
  parameter int SEQW  = 8,
  parameter int NWAKE = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  disp_vld,
  output logic                  disp_rdy,
  input  logic                  disp_st,
  input  logic                  disp_vec,
  input  logic [SEQW-1:0]       disp_seq,
  input  logic [TAGW-1:0]       disp_a0_tag,
  input  logic                  disp_a0_rdy,
  input  logic [TAGW-1:0]       disp_a1_tag,
  input  logic                  disp_a1_rdy,
  input  logic [TAGW-1:0]       disp_d_tag,
  input  logic                  disp_d_rdy,
  input  logic [NWAKE-1:0]      wk_vld,
  input  logic [NWAKE*TAGW-1:0] wk_tag,
  input  logic                  flush_vld,
  input  logic [SEQW-1:0]       flush_seq,
  output logic                  ld_vld,
  output logic [SEQW-1:0]       ld_seq,
  output logic                  ld_vec,
  output logic                  st_vld,
  output logic [SEQW-1:0]       st_seq,
  output logic                  st_vec,
  output logic [TAGW-1:0]       st_dtag,
  output logic                  st_drdy
);
  localparam int IDXW = $clog2(DEPTH);

  logic [DEPTH-1:0] v, st, vec, r0, r1, rd;
  logic [TAGW-1:0]  t0 [DEPTH];
  logic [TAGW-1:0]  t1 [DEPTH];
  logic [TAGW-1:0]  td [DEPTH];
  logic [SEQW-1:0]  sq [DEPTH];

  logic [DEPTH-1:0] blocked, ld_el, st_el, ld_win;
  logic [IDXW-1:0]  ld_idx, st_idx, fr_idx;
  logic             take;

  function automatic logic older(input logic [SEQW-1:0] a, input logic [SEQW-1:0] b);
    logic [SEQW-1:0] d;
    d = a - b;
    return d[SEQW-1];
  endfunction

  function automatic logic woke(input logic [TAGW-1:0] t);
    logic h;
    h = 1'b0;
    for (int k = 0; k < NWAKE; k++)
      if (wk_vld[k] && wk_tag[k*TAGW +: TAGW] == t) h = 1'b1;
    return h;
  endfunction

  always_comb begin
    blocked = '0;
    for (int i = 0; i < DEPTH; i++)
      for (int j = 0; j < DEPTH; j++)
        if (v[j] && st[j] && older(sq[j], sq[i])) blocked[i] = 1'b1;
  end

  assign ld_el = v & ~st & r0 & r1 & ~blocked;
  assign st_el = v &  st & r0 & r1 & ~blocked;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ld_win[i] = ld_el[i];
      for (int j = 0; j < DEPTH; j++)
        if (ld_el[j] && older(sq[j], sq[i])) ld_win[i] = 1'b0;
    end
  end

  always_comb begin
    ld_idx = '0;
    st_idx = '0;
    fr_idx = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (ld_win[i]) ld_idx = IDXW'(i);
      if (st_el[i])  st_idx = IDXW'(i);
      if (!v[i])     fr_idx = IDXW'(i);
    end
  end

  assign disp_rdy = ~&v;
  assign take     = disp_vld & disp_rdy & ~(flush_vld & older(flush_seq, disp_seq));

  assign ld_vld  = |ld_el & ~flush_vld;
  assign ld_seq  = sq[ld_idx];
  assign ld_vec  = vec[ld_idx];
  assign st_vld  = |st_el & ~flush_vld;
  assign st_seq  = sq[st_idx];
  assign st_vec  = vec[st_idx];
  assign st_dtag = td[st_idx];
  assign st_drdy = rd[st_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v  <= '0;
      r0 <= '0;
      r1 <= '0;
      rd <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (v[i] && !r0[i] && woke(t0[i])) r0[i] <= 1'b1;
        if (v[i] && !r1[i] && woke(t1[i])) r1[i] <= 1'b1;
        if (v[i] && !rd[i] && woke(td[i])) rd[i] <= 1'b1;
        if (flush_vld && older(flush_seq, sq[i])) v[i] <= 1'b0;
      end
      if (ld_vld) v[ld_idx] <= 1'b0;
      if (st_vld) v[st_idx] <= 1'b0;
      if (take) begin
        v[fr_idx]  <= 1'b1;
        r0[fr_idx] <= disp_a0_rdy | woke(disp_a0_tag);
        r1[fr_idx] <= disp_a1_rdy | woke(disp_a1_tag);
        rd[fr_idx] <= disp_d_rdy  | woke(disp_d_tag);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      st[fr_idx]  <= disp_st;
      vec[fr_idx] <= disp_vec;
      sq[fr_idx]  <= disp_seq;
      t0[fr_idx]  <= disp_a0_tag;
      t1[fr_idx]  <= disp_a1_tag;
      td[fr_idx]  <= disp_d_tag;
    end
  end
endmodule

// File: rtl/mem_issue_queue_chk.sv
module mem_issue_queue_chk #(
  parameter int DEPTH = 16,
  parameter int SEQW  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_vld,
  input logic [SEQW-1:0]  flush_seq,
  input logic             ld_vld,
  input logic [SEQW-1:0]  ld_seq,
  input logic             st_vld,
  input logic [SEQW-1:0]  st_seq,
  input logic [DEPTH-1:0] v,
  input logic [DEPTH-1:0] st,
  input logic [SEQW-1:0]  sq [DEPTH]
);
  function automatic logic older(input logic [SEQW-1:0] a, input logic [SEQW-1:0] b);
    logic [SEQW-1:0] d;
    d = a - b;
    return d[SEQW-1];
  endfunction

  logic            ld_in_q, st_before_ld, young_left;
  logic            have_st, fl_q;
  logic [SEQW-1:0] last_st, fl_seq_q;
  int              cnt;

  always_comb begin
    ld_in_q = 1'b0;
    st_before_ld = 1'b0;
    young_left = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (v[i] && !st[i] && sq[i] == ld_seq) ld_in_q = 1'b1;
      if (v[i] && st[i] && older(sq[i], ld_seq)) st_before_ld = 1'b1;
      if (v[i] && older(fl_seq_q, sq[i])) young_left = 1'b1;
    end
  end

  assign cnt = $countones(v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_st  <= 1'b0;
      last_st  <= '0;
      fl_q     <= 1'b0;
      fl_seq_q <= '0;
    end else begin
      if (st_vld) begin
        have_st <= 1'b1;
        last_st <= st_seq;
      end
      fl_q     <= flush_vld;
      fl_seq_q <= flush_seq;
    end
  end

  p_fill_rate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= $past(cnt) + 1) else $error("occupancy grew by more than one");

  p_ld_from_q_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vld |-> ld_in_q) else $error("issued load not held in queue");

  p_ld_behind_st_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vld |-> !st_before_ld) else $error("load passed an older store");

  p_st_in_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_vld && have_st) |-> older(last_st, st_seq)) else $error("store issued out of order");

  p_flush_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fl_q |-> !young_left) else $error("entry younger than flush boundary survived");
endmodule

bind mem_issue_queue mem_issue_queue_chk #(.DEPTH(DEPTH), .SEQW(SEQW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_vld(flush_vld), .flush_seq(flush_seq),
  .ld_vld(ld_vld), .ld_seq(ld_seq), .st_vld(st_vld), .st_seq(st_seq),
  .v(v), .st(st), .sq(sq)
);

// File: tb/mem_issue_queue_test.sv
module mem_issue_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int TAGW  = 6;
  localparam int SEQW  = 8;
  localparam int NWAKE = 2;

  logic clk = 0, rst_n = 0;
  logic disp_vld = 0, disp_rdy, disp_st = 0, disp_vec = 0;
  logic [SEQW-1:0] disp_seq = '0;
  logic [TAGW-1:0] disp_a0_tag = '0, disp_a1_tag = '0, disp_d_tag = '0;
  logic disp_a0_rdy = 0, disp_a1_rdy = 0, disp_d_rdy = 0;
  logic [NWAKE-1:0] wk_vld = '0;
  logic [NWAKE*TAGW-1:0] wk_tag = '0;
  logic flush_vld = 0;
  logic [SEQW-1:0] flush_seq = '0;
  logic ld_vld, ld_vec, st_vld, st_vec, st_drdy;
  logic [SEQW-1:0] ld_seq, st_seq;
  logic [TAGW-1:0] st_dtag;

  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_issue_queue #(.DEPTH(DEPTH), .TAGW(TAGW), .SEQW(SEQW), .NWAKE(NWAKE)) uut (
    .clk(clk), .rst_n(rst_n), .disp_vld(disp_vld), .disp_rdy(disp_rdy),
    .disp_st(disp_st), .disp_vec(disp_vec), .disp_seq(disp_seq),
    .disp_a0_tag(disp_a0_tag), .disp_a0_rdy(disp_a0_rdy),
    .disp_a1_tag(disp_a1_tag), .disp_a1_rdy(disp_a1_rdy),
    .disp_d_tag(disp_d_tag), .disp_d_rdy(disp_d_rdy),
    .wk_vld(wk_vld), .wk_tag(wk_tag), .flush_vld(flush_vld), .flush_seq(flush_seq),
    .ld_vld(ld_vld), .ld_seq(ld_seq), .ld_vec(ld_vec),
    .st_vld(st_vld), .st_seq(st_seq), .st_vec(st_vec),
    .st_dtag(st_dtag), .st_drdy(st_drdy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic present(input bit s, input bit vc, input int sqv, input int at, input bit ar,
                         input int dt, input bit dr);
    disp_vld = 1; disp_st = s; disp_vec = vc; disp_seq = SEQW'(sqv);
    disp_a0_tag = TAGW'(at); disp_a0_rdy = ar;
    disp_a1_tag = '0; disp_a1_rdy = 1;
    disp_d_tag = TAGW'(dt); disp_d_rdy = dr;
  endtask

  task automatic disp(input bit s, input bit vc, input int sqv, input int at, input bit ar,
                      input int dt, input bit dr);
    present(s, vc, sqv, at, ar, dt, dr);
    @(negedge clk);
    disp_vld = 0;
  endtask

  task automatic wake(input int port, input int tag);
    wk_vld[port] = 1;
    wk_tag[port*TAGW +: TAGW] = TAGW'(tag);
    @(negedge clk);
    wk_vld = '0;
  endtask

  task automatic t_reset;
    check("R1", "disp_rdy after reset", int'(disp_rdy), 1);
    check("R7", "ld_vld after reset", int'(ld_vld), 0);
    check("R7", "st_vld after reset", int'(st_vld), 0);
  endtask

  task automatic t_wakeup;
    disp(0, 0, 1, 5, 0, 0, 1);
    check("R2", "load waits for address", int'(ld_vld), 0);
    wake(0, 5);
    check("R8", "load woken", int'(ld_vld), 1);
    check("R2", "woken load seq", int'(ld_seq), 1);
    @(negedge clk);
    check("R2", "issued load gone", int'(ld_vld), 0);
  endtask

  task automatic t_oldest;
    disp(0, 0, 12, 7, 0, 0, 1);
    disp(0, 0, 10, 7, 0, 0, 1);
    disp(0, 0, 11, 7, 0, 0, 1);
    wake(1, 7);
    check("R3", "first oldest", int'(ld_seq), 10);
    @(negedge clk);
    check("R3", "second oldest", int'(ld_seq), 11);
    @(negedge clk);
    check("R3", "third oldest", int'(ld_seq), 12);
    @(negedge clk);
    check("R3", "drained", int'(ld_vld), 0);
  endtask

  task automatic t_wrap;
    disp(0, 0, 0, 8, 0, 0, 1);
    disp(0, 0, 255, 8, 0, 0, 1);
    disp(0, 0, 254, 8, 0, 0, 1);
    wake(0, 8);
    check("R3", "wrap first", int'(ld_seq), 254);
    @(negedge clk);
    check("R3", "wrap second", int'(ld_seq), 255);
    @(negedge clk);
    check("R3", "wrap third", int'(ld_seq), 0);
    @(negedge clk);
  endtask

  task automatic t_ld_vs_st;
    disp(1, 0, 20, 9, 0, 0, 1);
    disp(0, 0, 21, 0, 1, 0, 1);
    check("R4", "load behind unready store", int'(ld_vld), 0);
    disp(0, 0, 19, 0, 1, 0, 1);
    check("R4", "older load passes", int'(ld_vld), 1);
    check("R4", "older load seq", int'(ld_seq), 19);
    @(negedge clk);
    check("R4", "younger load still blocked", int'(ld_vld), 0);
    wake(0, 9);
    check("R4", "store issues", int'(st_vld), 1);
    check("R4", "store seq", int'(st_seq), 20);
    check("R4", "load blocked while store in queue", int'(ld_vld), 0);
    @(negedge clk);
    check("R4", "load after store left", int'(ld_vld), 1);
    check("R4", "load seq after store", int'(ld_seq), 21);
    @(negedge clk);
  endtask

  task automatic t_store_order;
    disp(1, 0, 30, 11, 0, 12, 0);
    disp(1, 0, 31, 0, 1, 12, 0);
    check("R5", "younger store waits", int'(st_vld), 0);
    wake(0, 11);
    check("R5", "older store first", int'(st_seq), 30);
    check("R6", "data not ready", int'(st_drdy), 0);
    @(negedge clk);
    check("R5", "younger store next", int'(st_seq), 31);
    check("R6", "data still not ready", int'(st_drdy), 0);
    @(negedge clk);
    check("R5", "stores drained", int'(st_vld), 0);
    disp(1, 0, 32, 0, 1, 13, 0);
    check("R6", "store issues without data", int'(st_vld), 1);
    check("R6", "data tag carried", int'(st_dtag), 13);
    disp(1, 0, 33, 14, 0, 15, 0);
    check("R6", "store waits for address", int'(st_vld), 0);
    wake(1, 15);
    check("R6", "data alone does not issue", int'(st_vld), 0);
    wake(0, 14);
    check("R6", "store issues", int'(st_seq), 33);
    check("R8", "data woken", int'(st_drdy), 1);
    @(negedge clk);
  endtask

  task automatic t_dual;
    disp(1, 0, 40, 16, 0, 0, 1);
    disp(0, 0, 39, 16, 0, 0, 1);
    wake(0, 16);
    check("R7", "dual load valid", int'(ld_vld), 1);
    check("R7", "dual store valid", int'(st_vld), 1);
    check("R7", "dual load seq", int'(ld_seq), 39);
    check("R7", "dual store seq", int'(st_seq), 40);
    @(negedge clk);
    check("R7", "dual drained", int'(ld_vld) + int'(st_vld), 0);
  endtask

  task automatic t_capture;
    present(0, 0, 50, 20, 0, 0, 1);
    wk_vld[0] = 1; wk_tag[0 +: TAGW] = TAGW'(20);
    @(negedge clk);
    disp_vld = 0; wk_vld = '0;
    check("R8", "same-cycle capture", int'(ld_vld), 1);
    check("R8", "captured seq", int'(ld_seq), 50);
    @(negedge clk);
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH; i++) disp(0, 0, 60 + i, 21, 0, 0, 1);
    check("R1", "full stalls", int'(disp_rdy), 0);
    disp(0, 0, 76, 0, 1, 0, 1);
    check("R1", "dropped dispatch not issued", int'(ld_vld), 0);
    wake(0, 21);
    for (int i = 0; i < DEPTH; i++) begin
      check("R1", "drain order", int'(ld_seq) * int'(ld_vld), 60 + i);
      if (i == 1) check("R1", "space after issue", int'(disp_rdy), 1);
      @(negedge clk);
    end
    check("R1", "nothing after drain", int'(ld_vld), 0);
  endtask

  task automatic t_flush;
    disp(0, 0, 80, 22, 0, 0, 1);
    disp(0, 0, 81, 22, 0, 0, 1);
    disp(0, 0, 82, 22, 0, 0, 1);
    disp(1, 0, 83, 22, 0, 0, 1);
    flush_vld = 1; flush_seq = 81;
    present(0, 0, 84, 0, 1, 0, 1);
    @(negedge clk);
    flush_vld = 0; disp_vld = 0;
    check("R9", "same-cycle younger dispatch dropped", int'(ld_vld), 0);
    wake(0, 22);
    check("R9", "old load kept", int'(ld_seq), 80);
    check("R9", "young store removed", int'(st_vld), 0);
    @(negedge clk);
    check("R9", "boundary load kept", int'(ld_seq), 81);
    @(negedge clk);
    check("R9", "young loads removed", int'(ld_vld), 0);
    disp(0, 0, 85, 0, 1, 0, 1);
    check("R9", "load ready before flush", int'(ld_vld), 1);
    flush_vld = 1; flush_seq = 90;
    #1;
    check("R9", "no issue during flush", int'(ld_vld), 0);
    @(negedge clk);
    flush_vld = 0;
    #1;
    check("R9", "older entry survives flush", int'(ld_seq) * int'(ld_vld), 85);
    @(negedge clk);
  endtask

  task automatic t_vec;
    disp(0, 1, 100, 0, 1, 0, 1);
    check("R10", "load vector flag", int'(ld_vec), 1);
    disp(1, 1, 101, 0, 1, 0, 1);
    check("R10", "store vector flag", int'(st_vec), 1);
    disp(1, 0, 102, 0, 1, 0, 1);
    check("R10", "store scalar flag", int'(st_vec), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_wakeup();
    t_oldest();
    t_wrap();
    t_ld_vs_st();
    t_store_order();
    t_dual();
    t_capture();
    t_full();
    t_flush();
    t_vec();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule